// File: doc/BRIEF.md
# DDR2 Clock-Enable Power-State Monitor

This block watches the command pins and the clock-enable pin that a DDR2 memory controller drives toward its memory. On every rising clock edge it decodes the command, compares the clock-enable level with the level seen at the edge before, and follows the memory through its power states. These states are idle, bank(s) active, precharge power-down, active power-down, self refresh, the command-restricted window right after self-refresh exit, and the read-wait stretch that follows it. The controller also supplies two status bits: whether any bank is open, and whether a read, write, mode-register, precharge or refresh operation is still running.

The current power state is reported one-hot. Any transition the protocol does not allow, or any timing rule that is broken, sets a sticky error flag. An error code records the first cause. Only a reset clears the flag, and the reset stands in for the memory's full reinitialization. The monitor never drives the bus. It is meant for simulation benches and for on-chip protocol checking alongside a controller.

Top module: `ddr2_power_state_mon`

## Requirements
- R1: `rst` is synchronous and active high. After reset the state is idle, `err_flag` is 0 and `err_code` is 0, and the clock-enable level at the previous edge is taken as high.
- R2: `state_onehot` always has exactly one bit set. The bits are: bit0 idle, bit1 active, bit2 precharge power-down, bit3 active power-down, bit4 self refresh, bit5 exit window, bit6 read wait. While in idle or active with clock-enable high at both edges, the next state is active if `bank_open` is 1 and idle otherwise.
- R3: In either power-down state or in self refresh, clock-enable low at both edges keeps the state unchanged. The command and `op_busy` are then ignored, and no error is raised.
- R4: A clock-enable rise exits a low-power state. Precharge power-down goes to idle, active power-down goes to active, and self refresh goes to the exit window. The move is always taken, but a command other than NOP or DESELECT at that edge raises error code 2.
- R5: From idle or active, clock-enable falling with NOP or DESELECT enters active power-down when `bank_open` is 1 and precharge power-down when it is 0.
- R6: From idle or active, clock-enable falling with AUTOREFRESH enters self refresh. If `bank_open` is 1 this raises error code 4. A fall with any command other than NOP, DESELECT or AUTOREFRESH raises error code 3.
- R7: A clock-enable fall from idle or active while `op_busy` is 1 raises error code 5.
- R8: If clock-enable changes at edge N and changes again at edge N+1 or N+2, error code 1 is raised. A change at N+3 or later is allowed.
- R9: Let E be the self-refresh exit edge. At edges E+1 through E+SRX_WIN, the command must be NOP or DESELECT, or error code 6 is raised. The state moves from exit window to read wait at edge E+SRX_WIN.
- R10: A read (select low, row strobe high, column strobe low, write strobe high) at edge E+k raises error code 7 when k < RD_WAIT and is accepted when k >= RD_WAIT. Read wait returns to idle or active at edge E+RD_WAIT-1. Other commands after the exit window are accepted.
- R11: A clock-enable fall during the exit window or the read wait raises error code 8.
- R12: `err_flag` stays set until reset. `err_code` holds the cause of the first error and stays unchanged after that. When several causes occur at the same edge, the lowest code is kept.
- R13: Command decode: DESELECT is `cmd_sel_n` high. NOP is select low with row, column and write strobes high. AUTOREFRESH is select, row and column low with write high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Memory clock-enable level at this edge |
| cmd_sel_n | input | 1 | Chip select, active low |
| cmd_row_n | input | 1 | Row address strobe, active low |
| cmd_col_n | input | 1 | Column address strobe, active low |
| cmd_wr_n | input | 1 | Write enable strobe, active low |
| bank_open | input | 1 | At least one bank is open |
| op_busy | input | 1 | An operation that forbids power-down is in progress |
| state_onehot | output | 7 | Current power state, one-hot (R2 bit order) |
| err_flag | output | 1 | Sticky protocol error |
| err_code | output | 4 | Cause of the first error, 0 when none |

## Verification
The bound checker tests these properties on every cycle: the one-hot state encoding, that the error flag and code stay fixed once set, that a low-power state holds while clock-enable stays low, the exit from self refresh into the exit window, double clock-enable changes inside the hold span, and the entry rules that depend on `bank_open` and `op_busy`. Other rules depend on counting many edges after an exit or on which cause is recorded first. These are the exit-window and read-wait boundaries, the first-cause priority, and the effect of reset. The bench shows them by sweeping the command and its position across the whole window, and every entry command against both status bits.

// File: rtl/ckemon_pkg.sv
package ckemon_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_AREF  = 3'd2,
    CMD_READ  = 3'd3,
    CMD_OTHER = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACT  = 3'd1,
    ST_PPD  = 3'd2,
    ST_APD  = 3'd3,
    ST_SREF = 3'd4,
    ST_SRXW = 3'd5,
    ST_SRXR = 3'd6
  } pst_e;

  localparam int NUM_ST = 7;

  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_HOLD      = 4'd1,
    E_EXITCMD   = 4'd2,
    E_ENTCMD    = 4'd3,
    E_SRNOTIDLE = 4'd4,
    E_BUSY      = 4'd5,
    E_WINCMD    = 4'd6,
    E_EARLYRD   = 4'd7,
    E_EARLYPD   = 4'd8
  } err_e;

  localparam int NUM_ERR = 9;

endpackage

// File: rtl/ckemon_cmd_decode.sv
module ckemon_cmd_decode
  import ckemon_pkg::*;
(
  input  logic sel_n,
  input  logic row_n,
  input  logic col_n,
  input  logic wr_n,
  output cmd_e cmd
);

  always_comb begin
    if (sel_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({row_n, col_n, wr_n})
        3'b111:  cmd = CMD_NOP;
        3'b001:  cmd = CMD_AREF;
        3'b101:  cmd = CMD_READ;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/ckemon_hold_timer.sv
module ckemon_hold_timer #(
  parameter int HOLD_EDGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  output logic hold_viol
);

  localparam int HC_W = (HOLD_EDGES > 2) ? $clog2(HOLD_EDGES) : 1;

  logic            en_prev_q;
  logic [HC_W-1:0] cnt_q;
  logic            toggle;

  assign toggle    = clk_en ^ en_prev_q;
  assign hold_viol = toggle && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev_q <= 1'b1;
      cnt_q     <= '0;
    end else begin
      en_prev_q <= clk_en;
      if (toggle) begin
        cnt_q <= HC_W'(HOLD_EDGES - 1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ckemon_srx_timer.sv
module ckemon_srx_timer #(
  parameter int SRX_WIN = 10,
  parameter int RD_WAIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic sr_exit,
  output logic win_last,
  output logic rd_block,
  output logic rd_last
);

  localparam int WIN_W = $clog2(SRX_WIN + 1);
  localparam int RD_W  = $clog2(RD_WAIT + 1);

  logic [WIN_W-1:0] win_q;
  logic [RD_W-1:0]  rd_q;

  assign win_last = (win_q == WIN_W'(1));
  assign rd_block = (rd_q != '0);
  assign rd_last  = (rd_q == RD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      rd_q  <= '0;
    end else if (sr_exit) begin
      win_q <= WIN_W'(SRX_WIN);
      rd_q  <= RD_W'(RD_WAIT - 1);
    end else begin
      if (win_q != '0) win_q <= win_q - 1'b1;
      if (rd_q != '0)  rd_q  <= rd_q - 1'b1;
    end
  end

endmodule

// File: rtl/ckemon_fsm.sv
module ckemon_fsm
  import ckemon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  cmd_e              cmd,
  input  logic              bank_open,
  input  logic              op_busy,
  input  logic              hold_viol,
  input  logic              win_last,
  input  logic              rd_block,
  input  logic              rd_last,
  output logic              sr_exit,
  output logic [NUM_ST-1:0] state_onehot,
  output logic              err_flag,
  output logic [3:0]        err_code
);

  pst_e               state_q, nxt;
  logic [NUM_ERR-1:0] cause;
  err_e               code_now;
  err_e               code_q;
  logic               err_q;
  logic               is_nop;
  pst_e               settle, pd_dest;

  assign is_nop  = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  assign settle  = bank_open ? ST_ACT : ST_IDLE;
  assign pd_dest = bank_open ? ST_APD : ST_PPD;

  always_comb begin
    cause   = '0;
    nxt     = state_q;
    sr_exit = 1'b0;
    cause[E_HOLD] = hold_viol;
    case (state_q)
      ST_PPD, ST_APD, ST_SREF: begin
        if (clk_en) begin
          if (!is_nop) cause[E_EXITCMD] = 1'b1;
          if (state_q == ST_PPD) begin
            nxt = ST_IDLE;
          end else if (state_q == ST_APD) begin
            nxt = ST_ACT;
          end else begin
            nxt     = ST_SRXW;
            sr_exit = 1'b1;
          end
        end
      end
      ST_SRXW: begin
        if (!clk_en) begin
          cause[E_EARLYPD] = 1'b1;
          nxt = pd_dest;
        end else begin
          if (!is_nop) cause[E_WINCMD] = 1'b1;
          if (win_last) nxt = ST_SRXR;
        end
      end
      default: begin
        if (clk_en) begin
          if (state_q == ST_SRXR) begin
            if ((cmd == CMD_READ) && rd_block) cause[E_EARLYRD] = 1'b1;
            nxt = rd_last ? settle : ST_SRXR;
          end else begin
            nxt = settle;
          end
        end else begin
          if (state_q == ST_SRXR) cause[E_EARLYPD] = 1'b1;
          if (op_busy) cause[E_BUSY] = 1'b1;
          if (cmd == CMD_AREF) begin
            if (bank_open) cause[E_SRNOTIDLE] = 1'b1;
            nxt = ST_SREF;
          end else begin
            if (!is_nop) cause[E_ENTCMD] = 1'b1;
            nxt = pd_dest;
          end
        end
      end
    endcase
  end

  always_comb begin
    code_now = E_NONE;
    for (int i = NUM_ERR - 1; i >= 1; i--) begin
      if (cause[i]) code_now = err_e'(i[3:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      code_q  <= E_NONE;
    end else begin
      state_q <= nxt;
      if (!err_q && (cause != '0)) begin
        err_q  <= 1'b1;
        code_q <= code_now;
      end
    end
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_onehot
    assign state_onehot[g] = (state_q == pst_e'(g));
  end

  assign err_flag = err_q;
  assign err_code = code_q;

endmodule

// File: rtl/ddr2_power_state_mon.sv
module ddr2_power_state_mon
  import ckemon_pkg::*;
#(
  parameter int HOLD_EDGES = 3,
  parameter int SRX_WIN    = 10,
  parameter int RD_WAIT    = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clk_en,
  input  logic       cmd_sel_n,
  input  logic       cmd_row_n,
  input  logic       cmd_col_n,
  input  logic       cmd_wr_n,
  input  logic       bank_open,
  input  logic       op_busy,
  output logic [6:0] state_onehot,
  output logic       err_flag,
  output logic [3:0] err_code
);

  cmd_e cmd;
  logic hold_viol;
  logic sr_exit;
  logic win_last;
  logic rd_block;
  logic rd_last;

  ckemon_cmd_decode u_dec (
    .sel_n (cmd_sel_n),
    .row_n (cmd_row_n),
    .col_n (cmd_col_n),
    .wr_n  (cmd_wr_n),
    .cmd   (cmd)
  );

  ckemon_hold_timer #(.HOLD_EDGES(HOLD_EDGES)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .hold_viol (hold_viol)
  );

  ckemon_srx_timer #(.SRX_WIN(SRX_WIN), .RD_WAIT(RD_WAIT)) u_srx (
    .clk      (clk),
    .rst      (rst),
    .sr_exit  (sr_exit),
    .win_last (win_last),
    .rd_block (rd_block),
    .rd_last  (rd_last)
  );

  ckemon_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .clk_en       (clk_en),
    .cmd          (cmd),
    .bank_open    (bank_open),
    .op_busy      (op_busy),
    .hold_viol    (hold_viol),
    .win_last     (win_last),
    .rd_block     (rd_block),
    .rd_last      (rd_last),
    .sr_exit      (sr_exit),
    .state_onehot (state_onehot),
    .err_flag     (err_flag),
    .err_code     (err_code)
  );

endmodule

// File: rtl/ddr2_power_state_mon_chk.sv
module ddr2_power_state_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       clk_en,
  input logic       cmd_sel_n,
  input logic       cmd_row_n,
  input logic       cmd_col_n,
  input logic       cmd_wr_n,
  input logic       bank_open,
  input logic       op_busy,
  input logic [6:0] state_onehot,
  input logic       err_flag,
  input logic [3:0] err_code
);

  logic en_d, chg_d, chg;
  logic quiet, aref, awake, lowpwr;

  assign chg    = clk_en != en_d;
  assign quiet  = cmd_sel_n || (cmd_row_n && cmd_col_n && cmd_wr_n);
  assign aref   = !cmd_sel_n && !cmd_row_n && !cmd_col_n && cmd_wr_n;
  assign awake  = state_onehot[0] || state_onehot[1];
  assign lowpwr = state_onehot[2] || state_onehot[3] || state_onehot[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d  <= 1'b1;
      chg_d <= 1'b0;
    end else begin
      en_d  <= clk_en;
      chg_d <= chg;
    end
  end

  assert_state_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(state_onehot) == 1);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  assert_code_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> $stable(err_code));

  assert_code_nonzero_R12: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (err_code != 4'd0));

  assert_lowpwr_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (lowpwr && !clk_en) |=> $stable(state_onehot));

  assert_sr_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state_onehot[4] && clk_en) |=> state_onehot[5]);

  assert_hold_span_R8: assert property (@(posedge clk) disable iff (rst)
    (chg && chg_d) |=> err_flag);

  assert_busy_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (awake && !clk_en && op_busy) |=> err_flag);

  assert_apd_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (awake && !clk_en && quiet && bank_open) |=> state_onehot[3]);

  assert_sref_open_R6: assert property (@(posedge clk) disable iff (rst)
    (awake && !clk_en && aref && bank_open) |=> err_flag);

endmodule

bind ddr2_power_state_mon ddr2_power_state_mon_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .clk_en       (clk_en),
  .cmd_sel_n    (cmd_sel_n),
  .cmd_row_n    (cmd_row_n),
  .cmd_col_n    (cmd_col_n),
  .cmd_wr_n     (cmd_wr_n),
  .bank_open    (bank_open),
  .op_busy      (op_busy),
  .state_onehot (state_onehot),
  .err_flag     (err_flag),
  .err_code     (err_code)
);

// File: tb/ddr2_power_state_mon_tb_top.sv
`timescale 1ns/1ps
module ddr2_power_state_mon_tb_top;

  localparam int W   = 4;
  localparam int RDW = 12;

  localparam int C_DES = 0, C_NOP = 1, C_AREF = 2, C_READ = 3, C_OTH = 4;
  localparam int S_IDLE = 1, S_ACT = 2, S_PPD = 4, S_APD = 8, S_SREF = 16,
                 S_SRXW = 32, S_SRXR = 64;

  logic clk = 1'b0;
  logic rst, clk_en, cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n, bank_open, op_busy;
  logic [6:0] state_onehot;
  logic       err_flag;
  logic [3:0] err_code;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  ddr2_power_state_mon #(.HOLD_EDGES(3), .SRX_WIN(W), .RD_WAIT(RDW)) dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cmd_sel_n(cmd_sel_n),
    .cmd_row_n(cmd_row_n), .cmd_col_n(cmd_col_n), .cmd_wr_n(cmd_wr_n),
    .bank_open(bank_open), .op_busy(op_busy), .state_onehot(state_onehot),
    .err_flag(err_flag), .err_code(err_code)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cmd(input int c);
    case (c)
      C_DES:   {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = 4'b1111;
      C_NOP:   {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = 4'b0111;
      C_AREF:  {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = 4'b0001;
      C_READ:  {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = 4'b0101;
      default: {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = 4'b0011;
    endcase
  endtask

  task automatic step(input logic c, input int cmd, input logic bk, input logic bz);
    @(negedge clk);
    clk_en = c; set_cmd(cmd); bank_open = bk; op_busy = bz;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; clk_en = 1'b1; set_cmd(C_NOP); bank_open = 1'b0; op_busy = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  // Enter self refresh, hold low three edges, exit with NOP (edge E).
  task automatic sref_cycle();
    step(1, C_NOP, 0, 0);
    step(0, C_AREF, 0, 0);
    repeat (3) step(0, C_NOP, 0, 0);
    step(1, C_NOP, 0, 0);
  endtask

  function automatic int exp_entry(int c, int b, int z);
    if (c > C_AREF) return 3;
    if (c == C_AREF && b != 0) return 4;
    if (z != 0) return 5;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; clk_en = 1'b1; set_cmd(C_NOP); bank_open = 1'b0; op_busy = 1'b0;

    // R1: reset state
    do_reset();
    check_eq("R1 state", state_onehot, S_IDLE);
    check_eq("R1 err_flag", err_flag, 0);
    check_eq("R1 err_code", err_code, 0);

    // R2: idle/active follow bank_open while clock-enable stays high
    for (int r = 0; r < 4; r++) begin
      step(1, (r % 2 == 0) ? C_READ : C_NOP, r[0], 0);
      check_eq("R2 awake state", state_onehot, r[0] ? S_ACT : S_IDLE);
    end
    check_eq("R2 no error", err_flag, 0);

    // R5 R6 R7 R13: entry sweep over command, bank and busy
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 5; c++) begin
        for (int z = 0; z < 2; z++) begin
          int e;
          do_reset();
          step(1, C_NOP, b[0], 0);
          step(0, c, b[0], z[0]);
          e = exp_entry(c, b, z);
          check_eq("R5/R6/R7 entry code", err_code, e);
          check_eq("R5/R6/R7 entry flag", err_flag, (e != 0) ? 1 : 0);
          if (e == 0)
            check_eq("R5 R6 R13 entry state", state_onehot,
                     (c == C_AREF) ? S_SREF : (b != 0 ? S_APD : S_PPD));
        end
      end
    end

    // R3 R4: hold low with commands ignored, then exit with each command
    for (int pd = 0; pd < 3; pd++) begin
      for (int xc = 0; xc < 5; xc++) begin
        int bk, st;
        bk = (pd == 1) ? 1 : 0;
        st = (pd == 0) ? S_PPD : (pd == 1) ? S_APD : S_SREF;
        do_reset();
        step(1, C_NOP, bk[0], 0);
        step(0, (pd == 2) ? C_AREF : C_NOP, bk[0], 0);
        for (int j = 0; j < 3; j++) begin
          step(0, C_AREF + j, bk[0], j[0]);
          check_eq("R3 low state kept", state_onehot, st);
          check_eq("R3 low no error", err_flag, 0);
        end
        step(1, xc, bk[0], 0);
        check_eq("R4 exit code", err_code, (xc <= C_NOP) ? 0 : 2);
        check_eq("R4 exit state", state_onehot,
                 (pd == 0) ? S_IDLE : (pd == 1) ? S_ACT : S_SRXW);
      end
    end

    // R8: hold span, falling then rising
    for (int gap = 1; gap <= 4; gap++) begin
      do_reset();
      step(1, C_NOP, 0, 0);
      step(0, C_NOP, 0, 0);
      for (int j = 1; j < gap; j++) step(0, C_NOP, 0, 0);
      step(1, C_NOP, 0, 0);
      check_eq("R8 fall-rise code", err_code, (gap < 3) ? 1 : 0);
    end
    // R8: rising then falling
    for (int gap = 1; gap <= 4; gap++) begin
      do_reset();
      step(1, C_NOP, 0, 0);
      step(0, C_NOP, 0, 0);
      repeat (3) step(0, C_NOP, 0, 0);
      step(1, C_NOP, 0, 0);
      for (int j = 1; j < gap; j++) step(1, C_NOP, 0, 0);
      step(0, C_NOP, 0, 0);
      check_eq("R8 rise-fall code", err_code, (gap < 3) ? 1 : 0);
    end

    // R9 R10: command position sweep across the exit window and read wait
    for (int sel = 0; sel < 2; sel++) begin
      for (int k = 1; k <= RDW + 1; k++) begin
        int cs, e;
        cs = (sel == 0) ? C_READ : C_OTH;
        do_reset();
        sref_cycle();
        check_eq("R4 exit window entered", state_onehot, S_SRXW);
        for (int j = 1; j <= RDW + 1; j++) begin
          int es;
          step(1, (j == k) ? cs : C_NOP, 0, 0);
          es = (j < W) ? S_SRXW : (j < RDW - 1) ? S_SRXR : S_IDLE;
          check_eq("R9 R10 exit state", state_onehot, es);
        end
        e = (k <= W) ? 6 : ((cs == C_READ && k < RDW) ? 7 : 0);
        check_eq("R9 R10 exit code", err_code, e);
      end
    end

    // R11: clock-enable falls in exit window and in read wait
    for (int f = 0; f < 2; f++) begin
      int at;
      at = (f == 0) ? 3 : 6;
      do_reset();
      sref_cycle();
      for (int j = 1; j < at; j++) step(1, C_NOP, 0, 0);
      step(0, C_NOP, 0, 0);
      check_eq("R11 early fall code", err_code, 8);
    end

    // R12: sticky flag, first cause kept, reset clears
    do_reset();
    step(1, C_NOP, 0, 0);
    step(0, C_READ, 0, 0);
    check_eq("R12 first code", err_code, 3);
    step(1, C_READ, 0, 0);
    for (int j = 0; j < 4; j++) step(1, C_NOP, j[0], 0);
    check_eq("R12 flag sticky", err_flag, 1);
    check_eq("R12 code kept", err_code, 3);
    do_reset();
    check_eq("R12 R1 reset clears flag", err_flag, 0);
    check_eq("R12 R1 reset clears code", err_code, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule